// File: doc/BRIEF.md
# OFDM Subcarrier Mapper with Spectral-Correlation Signatures

This block builds one frequency-domain OFDM symbol at a time and hands it to an external IFFT as a stream of complex values in bin order. A symbol is a run of identical bandwidth slices of 64 carriers each. The number of slices is set by a run-time control input. Inside every slice the block places QAM data, fixed pilots and zero guards. It also repeats four of the slice's own data carriers at a constant carrier offset. Every slice carries the same repeat at the same spacing, so the whole symbol has one spectral correlation at one cyclic frequency. A receiver that looks at that single cyclic frequency can count the signatures and so estimate how much bandwidth is in use.

QAM symbols enter on a valid/ready stream and leave on a second valid/ready stream. The data input is only drawn on data carriers. While the block emits pilots, guards or signature repeats it holds `in_ready` low. The output stage is a single register. If the sink holds `out_ready` low, the presented carrier stays frozen and nothing upstream moves. The slice count is sampled once per symbol, at the moment the first bin of that symbol is produced. A count that changes in the middle of a symbol therefore only shapes the next symbol.

Top module: `ofdm_sig_mapper`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are 0. The first symbol after reset starts at slice 0, bin 0.
- R2: A symbol contains exactly 64*(`cfg_units`+1) output transfers. `cfg_units` is a 4-bit code: 0 means 1 slice and 15 means 16 slices. `out_sos` is 1 on the first transfer of a symbol and 0 on every other transfer.
- R3: Each slice has 56 data carriers. In bin order, they carry the accepted input symbols unchanged and in their arrival order, with no gap and no repeat across slices and symbols.
- R4: Bins 16 and 48 of every slice are pilots. Each pilot outputs real part `PILOT_AMP` (default 0x2000) and imaginary part 0.
- R5: Bins 0 (the DC guard) and 32 of every slice are guards and output 0 on both parts.
- R6: Bins 44 to 47 of every slice repeat bins 4 to 7 of the same slice, in the same order (offset 40). Bins 4 to 7 are data carriers.
- R7: `cfg_units` is sampled when bin 0 of a symbol is loaded. A change while a symbol is in flight has no effect on that symbol's length or content. The change applies from the next symbol.
- R8: While `out_valid` is 1 and `out_ready` is 0, the values of `out_re`, `out_im` and `out_sos` do not change, `out_valid` stays 1, and `in_ready` is 0.
- R9: `in_ready` is 1 only when the next bin to load is a data carrier and the output register is free or being drained. An input is consumed only on a cycle where both `in_valid` and `in_ready` are 1, and it appears at the output on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_units | input | 4 | Slice count minus one, sampled at each symbol start |
| in_valid | input | 1 | Input QAM symbol present |
| in_ready | output | 1 | Block takes the input symbol this cycle |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| out_valid | output | 1 | Output carrier present |
| out_ready | input | 1 | Sink takes the output carrier this cycle |
| out_re | output | 16 | Output real part, signed |
| out_im | output | 16 | Output imaginary part, signed |
| out_sos | output | 1 | Output carrier is bin 0 of slice 0 of a symbol |

## Verification
The hardest situation to reach from the ports is a slice-count change that lands inside a running symbol while both streams are stalling. Only this case separates sampling at the symbol boundary from sampling at an arbitrary cycle. The stimulus table therefore rewrites `cfg_units` each time the observed output reaches bin 10 of the last symbol of a table row. Meanwhile, rotating masks on `out_ready` and `in_valid` make the boundary load happen on a cycle that depends on both stalls. The expected length of every symbol is taken from a queue that the bench fills at the moment of each change. The signature repeats are compared against the bench's own record of the data that went into bins 4 to 7 of the same slice, for slice counts from 1 to 16.

// File: rtl/sc_map_pkg.sv
package sc_map_pkg;

  typedef enum logic [1:0] {
    CK_DATA  = 2'd0,
    CK_PILOT = 2'd1,
    CK_GUARD = 2'd2,
    CK_COPY  = 2'd3
  } carrier_kind_e;

endpackage

// File: rtl/sc_carrier_class.sv
module sc_carrier_class
  import sc_map_pkg::*;
#(
  parameter int UNIT_LEN = 64,
  parameter int GUARD_A  = 0,
  parameter int GUARD_B  = 32,
  parameter int PILOT_A  = 16,
  parameter int PILOT_B  = 48,
  parameter int SRC_BASE = 4,
  parameter int NSIG     = 4,
  parameter int SIG_SEP  = 40,
  localparam int BIN_W   = $clog2(UNIT_LEN),
  localparam int IDX_W   = (NSIG > 1) ? $clog2(NSIG) : 1
) (
  input  logic [BIN_W-1:0] bin,
  output carrier_kind_e    kind,
  output logic [IDX_W-1:0] sig_idx,
  output logic             is_src
);

  localparam int COPY_LO = SRC_BASE + SIG_SEP;

  always_comb begin
    int b;
    b       = int'(bin);
    kind    = CK_DATA;
    sig_idx = '0;
    is_src  = 1'b0;
    if (b == GUARD_A || b == GUARD_B) begin
      kind = CK_GUARD;
    end else if (b == PILOT_A || b == PILOT_B) begin
      kind = CK_PILOT;
    end else if (b >= COPY_LO && b < COPY_LO + NSIG) begin
      kind    = CK_COPY;
      sig_idx = IDX_W'(b - COPY_LO);
    end else if (b >= SRC_BASE && b < SRC_BASE + NSIG) begin
      is_src  = 1'b1;
      sig_idx = IDX_W'(b - SRC_BASE);
    end
  end

endmodule

// File: rtl/sc_bin_seq.sv
module sc_bin_seq #(
  parameter int UNITS_MAX = 16,
  parameter int UNIT_LEN  = 64,
  localparam int BIN_W    = $clog2(UNIT_LEN),
  localparam int UCFG_W   = $clog2(UNITS_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [UCFG_W-1:0] cfg_units,
  output logic [BIN_W-1:0]  bin,
  output logic              first,
  output logic              last
);

  logic [BIN_W-1:0]  bin_q;
  logic [UCFG_W-1:0] unit_q;
  logic [UCFG_W-1:0] units_q;
  logic              end_of_unit;

  assign end_of_unit = (bin_q == BIN_W'(UNIT_LEN - 1));
  assign first       = (bin_q == '0) && (unit_q == '0);
  assign last        = end_of_unit && (unit_q == units_q);
  assign bin         = bin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_q   <= '0;
      unit_q  <= '0;
      units_q <= '0;
    end else if (adv) begin
      if (first) begin
        units_q <= cfg_units;
      end
      if (last) begin
        bin_q  <= '0;
        unit_q <= '0;
      end else if (end_of_unit) begin
        bin_q  <= '0;
        unit_q <= unit_q + 1'b1;
      end else begin
        bin_q <= bin_q + 1'b1;
      end
    end
  end

  // R2
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last) |=> first);

  // R7
  unit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first |-> (unit_q <= units_q));

endmodule

// File: rtl/sc_sig_mem.sv
module sc_sig_mem #(
  parameter int NSIG   = 4,
  parameter int DW     = 16,
  localparam int IDX_W = (NSIG > 1) ? $clog2(NSIG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic signed [DW-1:0] wr_re,
  input  logic signed [DW-1:0] wr_im,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic signed [DW-1:0] rd_re,
  output logic signed [DW-1:0] rd_im
);

  logic signed [DW-1:0] slot_re [NSIG];
  logic signed [DW-1:0] slot_im [NSIG];

  for (genvar g = 0; g < NSIG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_re[g] <= wr_re;
        slot_im[g] <= wr_im;
      end
    end
  end

  assign rd_re = slot_re[rd_idx];
  assign rd_im = slot_im[rd_idx];

  logic [NSIG-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (wr_en) begin
      seen_q[wr_idx] <= 1'b1;
    end
  end

  // R6
  copy_after_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> seen_q[rd_idx]);

endmodule

// File: rtl/ofdm_sig_mapper.sv
module ofdm_sig_mapper
  import sc_map_pkg::*;
#(
  parameter int DW        = 16,
  parameter int UNITS_MAX = 16,
  parameter int UNIT_LEN  = 64,
  parameter int GUARD_A   = 0,
  parameter int GUARD_B   = 32,
  parameter int PILOT_A   = 16,
  parameter int PILOT_B   = 48,
  parameter int SRC_BASE  = 4,
  parameter int NSIG      = 4,
  parameter int SIG_SEP   = 40,
  parameter logic signed [DW-1:0] PILOT_AMP = 16'sh2000,
  localparam int BIN_W    = $clog2(UNIT_LEN),
  localparam int UCFG_W   = $clog2(UNITS_MAX),
  localparam int IDX_W    = (NSIG > 1) ? $clog2(NSIG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [UCFG_W-1:0]    cfg_units,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 out_sos
);

  if (SRC_BASE + SIG_SEP + NSIG > UNIT_LEN) begin : g_bad_span
    $error("signature repeat leaves the slice");
  end
  if (SIG_SEP < NSIG) begin : g_bad_sep
    $error("signature repeat overlaps its sources");
  end

  logic [BIN_W-1:0]     bin;
  logic                 first;
  logic                 last;
  carrier_kind_e        kind;
  logic [IDX_W-1:0]     sig_idx;
  logic                 is_src;
  logic signed [DW-1:0] rep_re;
  logic signed [DW-1:0] rep_im;
  logic                 slot_free;
  logic                 fire;
  logic                 is_data;
  logic signed [DW-1:0] nxt_re;
  logic signed [DW-1:0] nxt_im;

  logic                 ov_q;
  logic                 sos_q;
  logic signed [DW-1:0] re_q;
  logic signed [DW-1:0] im_q;

  sc_bin_seq #(
    .UNITS_MAX (UNITS_MAX),
    .UNIT_LEN  (UNIT_LEN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (fire),
    .cfg_units (cfg_units),
    .bin       (bin),
    .first     (first),
    .last      (last)
  );

  sc_carrier_class #(
    .UNIT_LEN (UNIT_LEN),
    .GUARD_A  (GUARD_A),
    .GUARD_B  (GUARD_B),
    .PILOT_A  (PILOT_A),
    .PILOT_B  (PILOT_B),
    .SRC_BASE (SRC_BASE),
    .NSIG     (NSIG),
    .SIG_SEP  (SIG_SEP)
  ) u_class (
    .bin     (bin),
    .kind    (kind),
    .sig_idx (sig_idx),
    .is_src  (is_src)
  );

  sc_sig_mem #(
    .NSIG (NSIG),
    .DW   (DW)
  ) u_sig (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (fire && is_data && is_src),
    .wr_idx (sig_idx),
    .wr_re  (in_re),
    .wr_im  (in_im),
    .rd_en  (fire && (kind == CK_COPY)),
    .rd_idx (sig_idx),
    .rd_re  (rep_re),
    .rd_im  (rep_im)
  );

  assign is_data   = (kind == CK_DATA);
  assign slot_free = !ov_q || out_ready;
  assign in_ready  = rst_n && slot_free && is_data;
  assign fire      = rst_n && slot_free && (!is_data || in_valid);

  always_comb begin
    unique case (kind)
      CK_DATA:  begin nxt_re = in_re;     nxt_im = in_im; end
      CK_PILOT: begin nxt_re = PILOT_AMP; nxt_im = '0;    end
      CK_COPY:  begin nxt_re = rep_re;    nxt_im = rep_im; end
      default:  begin nxt_re = '0;        nxt_im = '0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      sos_q <= 1'b0;
      re_q  <= '0;
      im_q  <= '0;
    end else if (fire) begin
      ov_q  <= 1'b1;
      sos_q <= first;
      re_q  <= nxt_re;
      im_q  <= nxt_im;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_sos   = sos_q;
  assign out_re    = re_q;
  assign out_im    = im_q;

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) &&
                                   $stable(out_im) && $stable(out_sos)));

  // R9
  accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R5
  sos_is_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sos && (GUARD_A == 0)) |-> (out_re == '0 && out_im == '0));

endmodule

// File: tb/tb_ofdm_sig_mapper.sv
module tb_ofdm_sig_mapper;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        cfg_units = 4'd0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic signed [15:0] in_re = '0;
  logic signed [15:0] in_im = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic signed [15:0] out_re;
  logic signed [15:0] out_im;
  logic              out_sos;

  always #5 clk = ~clk;

  ofdm_sig_mapper dut (
    .clk (clk), .rst_n (rst_n), .cfg_units (cfg_units),
    .in_valid (in_valid), .in_ready (in_ready), .in_re (in_re), .in_im (in_im),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_re (out_re), .out_im (out_im), .out_sos (out_sos)
  );

  // {cfg_units, symbols, out_ready mask, in_valid mask}
  localparam logic [23:0] VEC [0:4] = '{
    24'h0_2_FF_FF, 24'hF_1_B7_DF, 24'h3_2_55_FF, 24'h1_1_FF_93, 24'h7_1_6D_F7
  };

  int n_run = 0, n_fail = 0;
  int cyc = 0, in_idx = 0, data_seen = 0, cnt = 0, started = 0, cur_units = 1;
  int exp_q[$];
  bit timeout = 0, hold = 0;
  logic [7:0] rmask = 8'hFF, vmask = 8'hFF;
  logic signed [15:0] sig_re [4], sig_im [4];

  function automatic logic signed [15:0] gen_re(int k);
    return 16'(k * 37 + 5);
  endfunction
  function automatic logic signed [15:0] gen_im(int k);
    return 16'(16'h4000 - k * 11);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic monitor();
    int b;
    logic signed [15:0] er, ei;
    if (!(out_valid && out_ready)) return;
    if (out_sos) begin
      if (started > 0) check(cnt == 64 * cur_units, "R2", "symbol length", cnt, 64 * cur_units);
      if (exp_q.size() > 0) cur_units = exp_q.pop_front();
      started++;
      cnt = 0;
    end else begin
      check(cnt != 0, "R2", "sos missing on bin 0", cnt, 0);
    end
    b = cnt % 64;
    if (b == 0 || b == 32) begin
      er = 0; ei = 0;                         // R5 guards
    end else if (b == 16 || b == 48) begin
      er = 16'sh2000; ei = 0;                 // R4 pilots
    end else if (b >= 44 && b <= 47) begin
      er = sig_re[b - 44]; ei = sig_im[b - 44];  // R6 repeats
    end else begin
      er = gen_re(data_seen); ei = gen_im(data_seen);  // R3 data order
      if (b >= 4 && b <= 7) begin
        sig_re[b - 4] = er; sig_im[b - 4] = ei;
      end
      data_seen++;
    end
    check(out_re == er && out_im == ei, "R3/R4/R5/R6", $sformatf("bin %0d re", b),
          out_re, er);
    cnt++;
  endtask

  task automatic step();
    @(negedge clk);
    out_ready = hold ? 1'b0 : rmask[cyc % 8];
    in_valid  = vmask[cyc % 8];
    in_re     = gen_re(in_idx);
    in_im     = gen_im(in_idx);
    #1;
    monitor();
    if (in_valid && in_ready) in_idx++;
    cyc++;
    if (cyc > 100000) timeout = 1;
  endtask

  initial begin
    int target;
    logic signed [15:0] hr, hi;
    logic hs;
    // R1: reset state with both sides willing
    cfg_units = VEC[0][23:20];
    exp_q.push_back(int'(VEC[0][23:20]) + 1);
    in_valid = 1; out_ready = 1;
    repeat (3) begin
      @(negedge clk); #1;
      check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
      check(in_ready == 0, "R1", "in_ready in reset", in_ready, 0);
    end
    @(negedge clk); rst_n = 1; #1;
    // R9: bin 0 is a guard, so no input is taken first
    check(in_ready == 0, "R9", "in_ready on guard bin 0", in_ready, 0);

    target = 0;
    for (int i = 0; i < 5; i++) begin
      rmask = VEC[i][15:8];
      vmask = VEC[i][7:0];
      target += int'(VEC[i][19:16]);
      while (!timeout && !(started == target && cnt >= 10)) step();
      // R7: change the count mid-symbol; it applies to the next symbol
      if (i < 4) begin
        cfg_units = VEC[i + 1][23:20];
        exp_q.push_back(int'(VEC[i + 1][23:20]) + 1);
      end else begin
        cfg_units = 4'd2;
      end
    end
    while (!timeout && cnt < 64 * cur_units) step();
    check(cnt == 64 * cur_units, "R2", "last symbol length", cnt, 64 * cur_units);
    check(started == target, "R7", "symbols seen", started, target);

    // R8: stall the sink and watch the held carrier
    hold = 1;
    step();
    hr = out_re; hi = out_im; hs = out_sos;
    check(out_valid == 1, "R8", "out_valid during stall", out_valid, 1);
    for (int k = 0; k < 6; k++) begin
      step();
      check(out_valid == 1 && out_re == hr && out_im == hi && out_sos == hs,
            "R8", "held carrier changed", out_re, hr);
      check(in_ready == 0, "R8", "in_ready during stall", in_ready, 0);
    end
    // R9: inputs consumed equal data carriers emitted
    check(in_idx == data_seen, "R9", "inputs consumed", in_idx, data_seen);
    check(!timeout, "R2", "watchdog", cyc, 100000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule